// File: doc/BRIEF.md
# UART Register Front End with Transmit Path

This block is the register-facing half of a serial port. A host reaches it through a one-cycle read/write port with byte offsets on a 32-bit word bus. Behind that port it keeps the port settings, turns a programmed baud word into a 16x oversample tick, buffers outgoing bytes in a small FIFO, and shifts them out on a single transmit line. Optional parity and a forced break level are supported on that line.

The receive deserializer is a separate block. This block feeds it a serial input, an enable, a FIFO-clear strobe and the shared oversample tick. Two receive conditions come back as inputs: data waiting and overrun. They join the transmit-empty flag in an interrupt status word. A mask held in the same register gates those flags onto a single interrupt line. A loopback setting routes the transmit line into the receiver input in place of the external pin.

A driver programs the baud word as half of clk/(16*baud), rounded, minus one. The tick then repeats every 2*(word+1) clocks, and one serial bit lasts 16 ticks.

Top module: `uart_frontend`

## Requirements
- R1: After reset the control word, baud word, FIFO settings and interrupt mask read as zero, `txd` is high, `irq` is low and the status word reads 0x0000_0020 (transmit FIFO empty).
- R2: Byte offsets: 0x00 control, 0x04 baud word (low 16 bits), 0x08 FIFO settings (bits 15:8 kept, the rest read 0), 0x10 interrupt, 0x14 data. Control keeps bits 14 and 18 to 23; bits 6 and 7 are write-only strobes that read as 0. Read data appears on `bus_rdata` one clock after `bus_rd`.
- R3: While control bit 23 is set, `os_tick` pulses for one clock every 2*(word+1) clocks; while it is clear, no tick occurs.
- R4: A frame is one low start bit, 8 data bits LSB first, an optional parity bit and one high stop bit, each lasting 16 ticks. A frame begins only when control bit 22 (transmit enable) is set and the FIFO holds a byte.
- R5: Control bit 19 adds a parity bit; bit 18 set gives even parity (the bit equals the XOR of the data), clear gives odd parity.
- R6: Writing offset 0x14 pushes bits 7:0 into a 16-entry FIFO; a write to a full FIFO is dropped; bytes leave in write order.
- R7: The status word (read at 0x10, bits 15:0) has bit 5 = transmit FIFO empty, bit 7 = `rx_overrun`, bit 11 = `rx_ready`. Bits 31:16 of the same read return the mask.
- R8: Writing 0x10 loads the mask from bits 31:16; mask bit n+16 enables status bit n. `irq` is the registered OR of status AND mask, one clock behind; a zero mask keeps `irq` low.
- R9: Writing control with bit 7 set empties the transmit FIFO, and its bytes are never sent. Writing control with bit 6 set drives `rx_flush` high for exactly one clock.
- R10: Control bit 14 holds `txd` low for as long as it is set.
- R11: With bit 22 clear `txd` stays high and queued bytes are held. `rx_enable` follows control bit 21.
- R12: With control bit 20 set, `rx_serial` carries `txd`; otherwise it carries `rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_ready | input | 1 | Receiver holds unread data |
| rx_overrun | input | 1 | Receiver overflowed |
| rxd | input | 1 | External serial input |
| txd | output | 1 | Serial transmit line |
| rx_serial | output | 1 | Serial input routed to the receiver |
| rx_enable | output | 1 | Receiver enable |
| rx_flush | output | 1 | One-clock receive FIFO clear strobe |
| os_tick | output | 1 | 16x oversample tick |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full transmit FIFO with an extra write arriving, because the serializer normally drains bytes as fast as they come. The stimulus holds transmit disabled while 17 bytes are written. It checks that the line stays high, then enables transmit. The scoreboard expects exactly the first 16 bytes in order, and any extra frame counts as a failure. The flush case uses the same method: the FIFO is filled while transmit is disabled and then cleared, and a later enable must produce no frame.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CTL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_BAUD = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_FCFG = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_IRQ  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_DATA = 5'h14;

  // control bit positions (decoded by software and the receiver)
  localparam int CB_RXCLR  = 6;
  localparam int CB_TXCLR  = 7;
  localparam int CB_BRK    = 14;
  localparam int CB_PEVEN  = 18;
  localparam int CB_PEN    = 19;
  localparam int CB_LOOP   = 20;
  localparam int CB_RXEN   = 21;
  localparam int CB_TXEN   = 22;
  localparam int CB_BRGEN  = 23;

  // status bit positions
  localparam int SB_TXEMPTY = 5;
  localparam int SB_RXOVR   = 7;
  localparam int SB_RXRDY   = 11;

  localparam int STAT_W = 16;

  typedef struct packed {
    logic brg_en;
    logic tx_en;
    logic rx_en;
    logic loop_en;
    logic par_en;
    logic par_even;
    logic brk;
  } ctl_t;
endpackage

// File: rtl/uart_fe_baud.sv
module uart_fe_baud #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BAUD_W-1:0] word,
  output logic              tick
);
  localparam int CW = BAUD_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  // period is 2*(word+1): count 0 .. 2*word+1
  assign last = {word, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R3: a tick is never followed directly by another one
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick) else $error("p_tick_gap_r3");
endmodule

// File: rtl/uart_fe_fifo.sv
module uart_fe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_push, do_pop;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  // R6: a write into a full FIFO leaves the write pointer untouched
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (full && push && !flush) |=> $stable(wptr)) else $error("p_no_overflow_r6");
endmodule

// File: rtl/uart_fe_txser.sv
module uart_fe_txser #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              avail,
  input  logic [DATA_W-1:0] data,
  output logic              pop,
  output logic              line,
  output logic              busy
);
  localparam int FW   = DATA_W + 3;
  localparam int BL_W = $clog2(FW + 1);

  logic [FW-1:0]   shreg;
  logic [BL_W-1:0] bits_left;
  logic [3:0]      phase;
  logic            par_bit;

  assign par_bit = par_even ? ^data : ~^data;
  assign pop     = en && !busy && tick && avail;
  assign line    = (en && busy) ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      phase     <= '0;
    end else if (!busy) begin
      if (pop) begin
        shreg     <= par_en ? {1'b1, par_bit, data, 1'b0} : {2'b11, data, 1'b0};
        bits_left <= par_en ? BL_W'(FW) : BL_W'(FW - 1);
        phase     <= '0;
        busy      <= 1'b1;
      end
    end else if (tick) begin
      if (phase == 4'd15) begin
        phase     <= '0;
        shreg     <= {1'b1, shreg[FW-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == BL_W'(1)) busy <= 1'b0;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R4: frames start only on an oversample tick
  p_load_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tick)) else $error("p_load_on_tick_r4");
endmodule

// File: rtl/uart_frontend.sv
module uart_frontend
  import uart_fe_pkg::*;
#(
  parameter int BAUD_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_ready,
  input  logic        rx_overrun,
  input  logic        rxd,
  output logic        txd,
  output logic        rx_serial,
  output logic        rx_enable,
  output logic        rx_flush,
  output logic        os_tick,
  output logic        irq
);
  localparam int DATA_W = 8;

  ctl_t              ctl;
  logic [BAUD_W-1:0] baud_q;
  logic [7:0]        fcfg_q;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] stat;
  logic [31:0]       ctl_word;

  logic wr_ctl, wr_baud, wr_fcfg, wr_irq, wr_data, tx_clr;
  logic fifo_empty, fifo_full, fifo_pop, ser_line, ser_busy;
  logic [DATA_W-1:0] fifo_dout;

  assign wr_ctl  = bus_wr && (bus_addr == OFF_CTL);
  assign wr_baud = bus_wr && (bus_addr == OFF_BAUD);
  assign wr_fcfg = bus_wr && (bus_addr == OFF_FCFG);
  assign wr_irq  = bus_wr && (bus_addr == OFF_IRQ);
  assign wr_data = bus_wr && (bus_addr == OFF_DATA);
  assign tx_clr  = wr_ctl && bus_wdata[CB_TXCLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      baud_q   <= '0;
      fcfg_q   <= '0;
      mask_q   <= '0;
      rx_flush <= 1'b0;
    end else begin
      rx_flush <= wr_ctl && bus_wdata[CB_RXCLR];
      if (wr_ctl) begin
        ctl.brg_en   <= bus_wdata[CB_BRGEN];
        ctl.tx_en    <= bus_wdata[CB_TXEN];
        ctl.rx_en    <= bus_wdata[CB_RXEN];
        ctl.loop_en  <= bus_wdata[CB_LOOP];
        ctl.par_en   <= bus_wdata[CB_PEN];
        ctl.par_even <= bus_wdata[CB_PEVEN];
        ctl.brk      <= bus_wdata[CB_BRK];
      end
      if (wr_baud) baud_q <= bus_wdata[BAUD_W-1:0];
      if (wr_fcfg) fcfg_q <= bus_wdata[15:8];
      if (wr_irq)  mask_q <= bus_wdata[31:16];
    end
  end

  always_comb begin
    stat             = '0;
    stat[SB_TXEMPTY] = fifo_empty;
    stat[SB_RXOVR]   = rx_overrun;
    stat[SB_RXRDY]   = rx_ready;
    ctl_word           = '0;
    ctl_word[CB_BRGEN] = ctl.brg_en;
    ctl_word[CB_TXEN]  = ctl.tx_en;
    ctl_word[CB_RXEN]  = ctl.rx_en;
    ctl_word[CB_LOOP]  = ctl.loop_en;
    ctl_word[CB_PEN]   = ctl.par_en;
    ctl_word[CB_PEVEN] = ctl.par_even;
    ctl_word[CB_BRK]   = ctl.brk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
      txd       <= 1'b1;
    end else begin
      irq <= |(stat & mask_q);
      txd <= ctl.brk ? 1'b0 : ser_line;
      if (bus_rd) begin
        unique case (bus_addr)
          OFF_CTL:  bus_rdata <= ctl_word;
          OFF_BAUD: bus_rdata <= 32'(baud_q);
          OFF_FCFG: bus_rdata <= {16'h0, fcfg_q, 8'h0};
          OFF_IRQ:  bus_rdata <= {mask_q, stat};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  assign rx_serial = ctl.loop_en ? txd : rxd;
  assign rx_enable = ctl.rx_en;

  uart_fe_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk(clk), .rst(rst), .en(ctl.brg_en), .word(baud_q), .tick(os_tick)
  );

  uart_fe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(tx_clr), .push(wr_data),
    .din(bus_wdata[DATA_W-1:0]), .pop(fifo_pop), .dout(fifo_dout),
    .empty(fifo_empty), .full(fifo_full)
  );

  uart_fe_txser #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .en(ctl.tx_en), .tick(os_tick),
    .par_en(ctl.par_en), .par_even(ctl.par_even),
    .avail(!fifo_empty && !tx_clr), .data(fifo_dout),
    .pop(fifo_pop), .line(ser_line), .busy(ser_busy)
  );

  // R10: break forces the line low
  p_brk_low_r10: assert property (@(posedge clk) disable iff (rst)
    ctl.brk |=> !txd) else $error("p_brk_low_r10");

  // R11: disabled transmitter keeps the line idle
  p_idle_high_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctl.tx_en && !ctl.brk) |=> txd) else $error("p_idle_high_r11");

  // R9: the transmit clear strobe leaves the FIFO empty
  p_txclr_r9: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> fifo_empty) else $error("p_txclr_r9");

  // R8: a zero mask keeps the interrupt low
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq) else $error("p_irq_mask_r8");
endmodule

// File: tb/uart_frontend_test.sv
module uart_frontend_test;
  localparam int BAUD_WORD = 1;
  localparam int TICK_P    = 2 * (BAUD_WORD + 1);
  localparam int BITLEN    = 16 * TICK_P;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_ready = 1'b0, rx_overrun = 1'b0, rxd = 1'b1;
  logic        txd, rx_serial, rx_enable, rx_flush, os_tick, irq;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  bit mon_on = 1'b1;
  logic [9:0] exp_q[$];   // {par_en, par_bit, data}

  always #4 clk = ~clk;

  uart_frontend uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rxd(rxd), .txd(txd), .rx_serial(rx_serial),
    .rx_enable(rx_enable), .rx_flush(rx_flush), .os_tick(os_tick), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic send(input logic [7:0] d, input bit pen, input bit peven, input bit expect_out);
    logic pb;
    pb = peven ? ^d : ~^d;
    if (expect_out) exp_q.push_back({pen, pb, d});
    bus_write(5'h14, {24'h0, d});
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (BITLEN * 12) @(negedge clk);
  endtask

  // monitor: decodes frames on txd and compares them with the scoreboard
  initial begin
    logic prev;
    logic [9:0] item;
    logic [10:0] got;
    int nb;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!mon_on || rst) begin
        prev = 1'b1;
      end else if (prev && !txd) begin
        frames++;
        if (exp_q.size() == 0) begin
          item = 10'h0;
          check(1'b0, "R6/R9 unexpected frame", 32'h1, 32'h0);
        end else begin
          item = exp_q.pop_front();
        end
        nb = item[9] ? 11 : 10;
        got = '1;
        repeat (BITLEN / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < nb; i++) begin
          repeat (BITLEN) @(negedge clk);
          got[i] = txd;
        end
        check(got[0] == 1'b0, "R4 start bit", {31'h0, got[0]}, 32'h0);
        check(got[8:1] == item[7:0], "R4 data LSB first", {24'h0, got[8:1]}, {24'h0, item[7:0]});
        if (item[9]) begin
          check(got[9] == item[8], "R5 parity bit", {31'h0, got[9]}, {31'h0, item[8]});
          check(got[10] == 1'b1, "R4 stop bit", {31'h0, got[10]}, 32'h1);
        end else begin
          check(got[9] == 1'b1, "R4 stop bit", {31'h0, got[9]}, 32'h1);
        end
        prev = txd;
      end else begin
        prev = txd;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int gap, cnt, seen;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(txd == 1'b1, "R1 txd idle", {31'h0, txd}, 32'h1);
    check(irq == 1'b0, "R1 irq low", {31'h0, irq}, 32'h0);
    bus_read(5'h00, rd); check(rd == 32'h0, "R1 control", rd, 32'h0);
    bus_read(5'h04, rd); check(rd == 32'h0, "R1 baud", rd, 32'h0);
    bus_read(5'h10, rd); check(rd == 32'h20, "R1 status", rd, 32'h20);

    // R2 readback
    bus_write(5'h00, 32'h0004_00C0);
    bus_read(5'h00, rd); check(rd == 32'h0004_0000, "R2 control strobes read 0", rd, 32'h0004_0000);
    bus_write(5'h04, 32'hABCD_1234);
    bus_read(5'h04, rd); check(rd == 32'h0000_1234, "R2 baud word", rd, 32'h0000_1234);
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, rd); check(rd == 32'h0000_FF00, "R2 fifo settings", rd, 32'h0000_FF00);
    bus_write(5'h04, BAUD_WORD);

    // R3 tick period
    bus_write(5'h00, 32'h0080_0000);
    while (!os_tick) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!os_tick);
      check(gap == TICK_P, "R3 tick period", gap, TICK_P);
    end
    bus_write(5'h00, 32'h0);
    cnt = 0;
    repeat (40) begin @(negedge clk); if (os_tick) cnt++; end
    check(cnt == 0, "R3 no tick when disabled", cnt, 0);

    // R4 plain frames
    bus_write(5'h00, 32'h00C0_0000);
    send(8'h55, 0, 0, 1); send(8'hA3, 0, 0, 1); send(8'h00, 0, 0, 1); send(8'hFF, 0, 0, 1);
    drain();

    // R5 parity even then odd
    bus_write(5'h00, 32'h00CC_0000);
    send(8'h07, 1, 1, 1); send(8'h03, 1, 1, 1);
    drain();
    bus_write(5'h00, 32'h00C8_0000);
    send(8'h07, 1, 0, 1); send(8'h81, 1, 0, 1);
    drain();

    // R6/R11 FIFO full with transmitter held off
    bus_write(5'h00, 32'h0080_0000);
    for (int i = 0; i < 17; i++) send(8'h30 + 8'(i), 0, 0, i < 16);
    bus_read(5'h10, rd); check(rd[5] == 1'b0, "R7 tx empty clear", rd, 32'h0);
    ok = 1'b1;
    repeat (300) begin @(negedge clk); if (!txd) ok = 1'b0; end
    check(ok, "R11 line idle while disabled", {31'h0, ok}, 32'h1);
    seen = frames;
    bus_write(5'h00, 32'h00C0_0000);
    drain();
    check(frames - seen == 16, "R6 only 16 frames", frames - seen, 16);
    bus_read(5'h10, rd); check(rd[5] == 1'b1, "R7 tx empty set", rd, 32'h20);

    // R9 transmit clear and receive clear strobe
    bus_write(5'h00, 32'h0080_0000);
    send(8'h11, 0, 0, 0); send(8'h22, 0, 0, 0); send(8'h33, 0, 0, 0);
    bus_write(5'h00, 32'h0080_0080);
    bus_read(5'h10, rd); check(rd[5] == 1'b1, "R9 flush empties FIFO", rd, 32'h20);
    seen = frames;
    bus_write(5'h00, 32'h00C0_0000);
    repeat (BITLEN * 12) @(negedge clk);
    check(frames == seen, "R9 flushed bytes not sent", frames - seen, 0);
    check(rx_flush == 1'b0, "R9 rx_flush idle", {31'h0, rx_flush}, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h00C0_0040;
    @(negedge clk);
    bus_wr = 1'b0;
    check(rx_flush == 1'b1, "R9 rx_flush pulse", {31'h0, rx_flush}, 32'h1);
    @(negedge clk);
    check(rx_flush == 1'b0, "R9 rx_flush one clock", {31'h0, rx_flush}, 32'h0);

    // R7/R8 status and interrupt masking
    rx_ready = 1'b1;
    bus_write(5'h10, 32'h0);
    @(negedge clk);
    check(irq == 1'b0, "R8 zero mask", {31'h0, irq}, 32'h0);
    bus_read(5'h10, rd); check(rd == 32'h0000_0820, "R7 ready status", rd, 32'h0000_0820);
    bus_write(5'h10, 32'h0800_0000);
    @(negedge clk);
    check(irq == 1'b1, "R8 ready irq", {31'h0, irq}, 32'h1);
    rx_ready = 1'b0;
    repeat (2) @(negedge clk);
    check(irq == 1'b0, "R8 irq follows status", {31'h0, irq}, 32'h0);
    rx_overrun = 1'b1;
    bus_write(5'h10, 32'h0080_0000);
    @(negedge clk);
    check(irq == 1'b1, "R8 overrun irq", {31'h0, irq}, 32'h1);
    bus_read(5'h10, rd); check(rd == 32'h0080_00A0, "R7 overrun status and mask", rd, 32'h0080_00A0);
    bus_write(5'h10, 32'h0);
    @(negedge clk);
    check(irq == 1'b0, "R8 masked again", {31'h0, irq}, 32'h0);
    rx_overrun = 1'b0;

    // R10 break, R12 loopback
    mon_on = 1'b0;
    bus_write(5'h00, 32'h00D0_4000);
    rxd = 1'b1;
    ok = 1'b1;
    repeat (200) begin @(negedge clk); if (txd) ok = 1'b0; end
    check(ok, "R10 break holds low", {31'h0, ok}, 32'h1);
    check(rx_serial == 1'b0, "R12 loopback carries break", {31'h0, rx_serial}, 32'h0);
    bus_write(5'h00, 32'h0010_0000);
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R10 break released", {31'h0, txd}, 32'h1);
    check(rx_serial == 1'b1, "R12 loopback ignores rxd", {31'h0, rx_serial}, 32'h1);
    bus_write(5'h00, 32'h0020_0000);
    @(negedge clk);
    check(rx_serial == 1'b0, "R12 pin path", {31'h0, rx_serial}, 32'h0);
    check(rx_enable == 1'b1, "R11 rx enable on", {31'h0, rx_enable}, 32'h1);
    bus_write(5'h00, 32'h0);
    check(rx_enable == 1'b0, "R11 rx enable off", {31'h0, rx_enable}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule